// File: doc/BRIEF.md
# LIN Interrupt Mask and Status Unit

This block gathers the event pulses of a LIN controller and turns them into sticky status bits and a single interrupt request. There are five sources: transmit ready, transmit complete, break received, collision detected and negative-edge count overflow. The event detectors sit elsewhere and present one-cycle pulses. Each source has its own mask bit, where a 1 disables its contribution to the interrupt. A sixth mask bit covers collision and transmit-complete together. Its collision suppression depends on the transmission state: it holds back collisions only once the transmit-finished flag is high.

The mask register is loaded through a simple write strobe. A send-checksum request sets the transmit-ready mask bit by itself. Software acknowledges a status bit with a write-one-to-clear strobe. Dropping the interface enable wipes every status bit.

Top module: `lin_irq_unit`

## Requirements
- R1: After reset, all status bits are 0, all six mask bits are 1 and irqOut is 0.
- R2: With linEn high, a pulse on evIn bit i sets statusOut bit i at the next clock edge. The index order is 0 transmit ready, 1 transmit complete, 2 break, 3 collision, 4 negative-edge overflow.
- R3: A status bit stays set until its statClr bit is pulsed. If an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R4: irqOut is high exactly when some status bit is set and its effective mask bit is 0. A mask bit of 1 disables that source.
- R5: Mask bit 5 (combined mask) also disables the transmit-complete source (status bit 1) in irqOut.
- R6: With mask bit 5 clear, a collision event sets status bit 3 whatever the level of txFinished.
- R7: With mask bit 5 set and txFinished high, a collision event does not set status bit 3.
- R8: With mask bit 5 set and txFinished low, a collision event still sets status bit 3.
- R9: A sendChk pulse sets mask bit 0 at the next edge. This takes priority over a mask write in the same cycle.
- R10: A set negative-edge status bit (bit 4) drives irqOut only while mask bit 4 is 0.
- R11: While linEn is low, all status bits clear at the next edge and events are ignored. The mask register keeps its value.
- R12: A maskWr pulse loads maskWrData into the mask register at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| linEn | input | 1 | Interface enable; low clears status |
| evIn | input | 5 | One-cycle event pulses, one per source |
| txFinished | input | 1 | Transmission-finished flag |
| statClr | input | 5 | Write-one-to-clear strobes for status |
| maskWr | input | 1 | Mask register write strobe |
| maskWrData | input | 6 | Mask value to load |
| sendChk | input | 1 | Send-checksum request pulse |
| statusOut | output | 5 | Sticky status bits |
| maskOut | output | 6 | Current mask register |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that evIn, statClr, maskWr and sendChk are single-cycle pulses sampled on the rising edge. They also assume that txFinished and linEn are steady levels around each edge. The stimulus changes every input only at the falling edge and returns each strobe to zero right after the edge that samples it. It exercises the collision rule in all three combinations of the combined mask and txFinished, and it places conflicting strobes (a set with a clear, a mask write with sendChk) in the same cycle on purpose.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int MASK_W  = NUM_SRC + 1;

  localparam int SRC_TXRDY  = 0;
  localparam int SRC_TXDONE = 1;
  localparam int SRC_BRK    = 2;
  localparam int SRC_COLL   = 3;
  localparam int SRC_NEGE   = 4;
  localparam int MSK_COMB   = NUM_SRC;

  typedef struct packed {
    logic [NUM_SRC-1:0] setStb;
    logic [NUM_SRC-1:0] clrStb;
    logic               clrAll;
    logic               maskLoad;
    logic               forceRdyMask;
  } ctlStb_t;
endpackage

// File: rtl/lin_irq_ctrl.sv
module lin_irq_ctrl
  import lin_irq_pkg::*;
(
  input  logic              linEn,
  input  logic [NUM_SRC-1:0] evIn,
  input  logic              txFinished,
  input  logic [NUM_SRC-1:0] statClr,
  input  logic              maskWr,
  input  logic              sendChk,
  input  logic [MASK_W-1:0] maskQ,
  output ctlStb_t           stb
);
  logic collBlock;

  always_comb begin
    // combined mask only holds back collisions after transmit finished
    collBlock = maskQ[MSK_COMB] & txFinished;
    stb = '0;
    stb.setStb = evIn & {NUM_SRC{linEn}};
    stb.setStb[SRC_COLL] = evIn[SRC_COLL] & linEn & ~collBlock;
    stb.clrStb = statClr;
    stb.clrAll = ~linEn;
    stb.maskLoad = maskWr;
    stb.forceRdyMask = sendChk;
  end
endmodule

// File: rtl/lin_irq_status.sv
module lin_irq_status
  import lin_irq_pkg::*;
#(
  parameter logic [MASK_W-1:0] MASK_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [MASK_W-1:0] maskWrData,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [MASK_W-1:0] maskQ,
  output logic              irq
);
  logic [MASK_W-1:0]  maskNext;
  logic [NUM_SRC-1:0] effMask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               statusQ[i] <= 1'b0;
      else if (stb.clrAll)     statusQ[i] <= 1'b0;
      else if (stb.setStb[i])  statusQ[i] <= 1'b1;
      else if (stb.clrStb[i])  statusQ[i] <= 1'b0;
    end
  end

  always_comb begin
    maskNext = stb.maskLoad ? maskWrData : maskQ;
    if (stb.forceRdyMask) maskNext[SRC_TXRDY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= MASK_RESET;
    else       maskQ <= maskNext;
  end

  always_comb begin
    effMask = maskQ[NUM_SRC-1:0];
    effMask[SRC_TXDONE] = maskQ[SRC_TXDONE] | maskQ[MSK_COMB];
    irq = |(statusQ & ~effMask);
  end
endmodule

// File: rtl/lin_irq_unit.sv
module lin_irq_unit
  import lin_irq_pkg::*;
#(
  parameter logic [MASK_W-1:0] MASK_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linEn,
  input  logic [NUM_SRC-1:0] evIn,
  input  logic              txFinished,
  input  logic [NUM_SRC-1:0] statClr,
  input  logic              maskWr,
  input  logic [MASK_W-1:0] maskWrData,
  input  logic              sendChk,
  output logic [NUM_SRC-1:0] statusOut,
  output logic [MASK_W-1:0] maskOut,
  output logic              irqOut
);
  ctlStb_t stb;

  lin_irq_ctrl u_ctrl (
    .linEn(linEn), .evIn(evIn), .txFinished(txFinished), .statClr(statClr),
    .maskWr(maskWr), .sendChk(sendChk), .maskQ(maskOut), .stb(stb)
  );

  lin_irq_status #(.MASK_RESET(MASK_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .maskWrData(maskWrData),
    .statusQ(statusOut), .maskQ(maskOut), .irq(irqOut)
  );
endmodule

// File: rtl/lin_irq_chk.sv
module lin_irq_chk
  import lin_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              linEn,
  input logic [NUM_SRC-1:0] evIn,
  input logic              txFinished,
  input logic [NUM_SRC-1:0] statClr,
  input logic              sendChk,
  input logic [NUM_SRC-1:0] statusOut,
  input logic [MASK_W-1:0] maskOut,
  input logic              irqOut
);
  assert_clear_on_disable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !linEn |=> statusOut == '0);

  assert_coll_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskOut[MSK_COMB] && txFinished && evIn[SRC_COLL] && !statusOut[SRC_COLL])
    |=> !statusOut[SRC_COLL]);

  // covers R6 and R8
  assert_coll_admit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (linEn && evIn[SRC_COLL] && !(maskOut[MSK_COMB] && txFinished))
    |=> statusOut[SRC_COLL]);

  assert_auto_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    sendChk |=> maskOut[SRC_TXRDY]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    linEn |=> (($past(statusOut) & ~$past(statClr) & ~statusOut) == '0));

  assert_all_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (&maskOut) |-> !irqOut);

  assert_negedge_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!maskOut[SRC_NEGE] && statusOut[SRC_NEGE]) |-> irqOut);
endmodule

bind lin_irq_unit lin_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .linEn(linEn), .evIn(evIn), .txFinished(txFinished),
  .statClr(statClr), .sendChk(sendChk), .statusOut(statusOut),
  .maskOut(maskOut), .irqOut(irqOut)
);

// File: tb/lin_irq_unit_tb.sv
module lin_irq_unit_tb;
  import lin_irq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linEn = 1'b0;
  logic [NUM_SRC-1:0] evIn = '0;
  logic txFinished = 1'b0;
  logic [NUM_SRC-1:0] statClr = '0;
  logic maskWr = 1'b0;
  logic [MASK_W-1:0] maskWrData = '0;
  logic sendChk = 1'b0;
  logic [NUM_SRC-1:0] statusOut;
  logic [MASK_W-1:0] maskOut;
  logic irqOut;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct {
    logic [NUM_SRC-1:0] st;
    logic [MASK_W-1:0]  mk;
    logic               irq;
    string              req;
  } exp_t;
  exp_t q[$];

  logic [NUM_SRC-1:0] mStat = '0;
  logic [MASK_W-1:0]  mMask = '1;

  always #10 clk = ~clk;

  lin_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .linEn(linEn), .evIn(evIn), .txFinished(txFinished),
    .statClr(statClr), .maskWr(maskWr), .maskWrData(maskWrData), .sendChk(sendChk),
    .statusOut(statusOut), .maskOut(maskOut), .irqOut(irqOut)
  );

  task automatic compare(input logic [NUM_SRC-1:0] st, input logic [MASK_W-1:0] mk,
                         input logic irq, input string req);
    nChk++;
    if (statusOut !== st || maskOut !== mk || irqOut !== irq) begin
      nFail++;
      $display("FAIL %s: status=%b mask=%b irq=%b expected status=%b mask=%b irq=%b",
               req, statusOut, maskOut, irqOut, st, mk, irq);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(input logic en, input logic txf, input logic [NUM_SRC-1:0] ev,
                       input logic [NUM_SRC-1:0] clr, input logic mwr,
                       input logic [MASK_W-1:0] mdat, input logic schk, input string req);
    logic [NUM_SRC-1:0] setv;
    logic [NUM_SRC-1:0] eff;
    exp_t e;
    @(negedge clk);
    linEn = en; txFinished = txf; evIn = ev; statClr = clr;
    maskWr = mwr; maskWrData = mdat; sendChk = schk;
    setv = en ? ev : '0;
    if (mMask[MSK_COMB] && txf) setv[SRC_COLL] = 1'b0;
    mStat = en ? ((mStat & ~clr) | setv) : '0;
    if (mwr) mMask = mdat;
    if (schk) mMask[SRC_TXRDY] = 1'b1;
    eff = mMask[NUM_SRC-1:0];
    if (mMask[MSK_COMB]) eff[SRC_TXDONE] = 1'b1;
    e.st = mStat; e.mk = mMask; e.irq = |(mStat & ~eff); e.req = req;
    q.push_back(e);
    @(posedge clk);
    #1;
    evIn = '0; statClr = '0; maskWr = 1'b0; sendChk = 1'b0;
  endtask

  // monitor: pops and compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.st, e.mk, e.irq, e.req);
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare('0, '1, 1'b0, "R1 reset state");
    rstN = 1'b1;
    // R2: event sets status, all masked so no irq (R4)
    drive(1, 0, 5'b00010, '0, 0, '0, 0, "R2 txdone event");
    // R12 mask load, R3 sticky, R4 irq
    drive(1, 0, '0, '0, 1, 6'h00, 0, "R12 mask write R4 irq");
    drive(1, 0, '0, 5'b00010, 0, '0, 0, "R3 clear strobe");
    // R5 combined mask hides txdone
    drive(1, 0, 5'b00010, '0, 1, 6'h20, 0, "R5 combined masks txdone");
    drive(1, 0, 5'b00010, 5'b00010, 0, '0, 0, "R3 set wins over clear");
    drive(1, 0, '0, 5'b00010, 0, '0, 0, "R3 clear");
    // collision rule
    drive(1, 1, 5'b01000, '0, 0, '0, 0, "R7 collision blocked");
    drive(1, 0, 5'b01000, '0, 0, '0, 0, "R8 collision before finish");
    drive(1, 0, '0, 5'b01000, 1, 6'h00, 0, "R3 clear collision");
    drive(1, 1, 5'b01000, '0, 0, '0, 0, "R6 collision unmasked finished");
    drive(1, 0, '0, 5'b01000, 1, 6'h10, 0, "R12 mask negedge");
    // negedge overflow
    drive(1, 0, 5'b10000, '0, 0, '0, 0, "R10 masked negedge");
    drive(1, 0, '0, '0, 1, 6'h00, 0, "R10 unmasked negedge");
    drive(1, 0, '0, '1, 1, 6'h00, 1, "R9 sendChk beats mask write");
    // disable
    drive(1, 0, 5'b00100, '0, 0, '0, 0, "R2 break event");
    drive(0, 0, 5'b00101, '0, 0, '0, 0, "R11 disable clears");
    drive(0, 0, 5'b11111, '0, 0, '0, 0, "R11 events ignored");
    drive(1, 0, '0, '0, 0, '0, 0, "R11 reenable idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule